// File: doc/BRIEF.md
# Hardwired Instruction Decode and Timing Front End

This block is the decode and timing front end of a hardwired controller for a small 16-bit accumulator machine. When the load strobe is high it captures a fetched instruction word, splits it into a 12-bit address field, a 3-bit operation code and a mode bit, and keeps the mode bit in a separate flip-flop. The operation code is decoded into eight one-hot operation lines.

A 4-bit sequence counter steps the controller through its timing states. The counter value is decoded into sixteen one-hot timing lines. The control equations outside this block combine these lines to form micro-operations. The counter can be cleared synchronously, stepped by one, or held. Clear takes priority over increment.

Top module: `hw_ctl_front`

## Requirements
- R1: On a rising clock edge with `ir_load_i` high, the instruction register captures `instr_i`. From that edge on, `addr_o` equals bits 11..0 of the captured word, unchanged.
- R2: While `ir_load_i` is low, the instruction register, `addr_o`, `op_o` and `mode_o` keep their values.
- R3: `op_o` is one-hot, and bit k is set where k is the binary value of bits 14..12 of the held instruction.
- R4: `mode_o` equals bit 15 of the last loaded instruction. A value of 0 selects direct addressing and 1 selects indirect addressing.
- R5: `timing_o` is one-hot, and bit n is set where n is the current sequence count (0 to 15).
- R6: With `sc_inc_i` high and `sc_clr_i` low, the count rises by one on each clock edge.
- R7: When the count is 15 and an increment is applied, the count wraps to 0.
- R8: With `sc_clr_i` high, the count is 0 after the next edge, whatever `sc_inc_i` is. Timing line 0 is then active.
- R9: With both `sc_inc_i` and `sc_clr_i` low, the count holds.
- R10: After reset, the instruction register, the mode flip-flop and the count are zero. So `op_o` = 8'h01, `mode_o` = 0, `addr_o` = 0 and `timing_o` = 16'h0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ir_load_i | input | 1 | Instruction register load strobe |
| instr_i | input | 16 | Fetched instruction word |
| sc_inc_i | input | 1 | Sequence counter increment |
| sc_clr_i | input | 1 | Sequence counter synchronous clear |
| op_o | output | 8 | One-hot decoded operation lines |
| mode_o | output | 1 | Addressing-mode flip-flop (1 = indirect) |
| addr_o | output | 12 | Address field of the held instruction |
| timing_o | output | 16 | One-hot timing lines |

## Verification
The assertions assume that every control input is a defined 0 or 1 at each sampled edge. They also assume that increment and clear may be high together, and that load may arrive in any timing state. No handshake or ordering between the strobes is assumed.

The stimulus draws all three strobes and the instruction word at random on every cycle, so all strobe combinations appear. It stays within these limits by driving inputs only on the falling edge. Directed runs add a full count to wrap, clear and increment asserted together, and long idle stretches.

// File: rtl/hw_ctl_pkg.sv
package hw_ctl_pkg;
  parameter int unsigned InstrW = 16;
  parameter int unsigned AddrW  = 12;
  parameter int unsigned OpW    = 3;
  parameter int unsigned SeqW   = 4;

  localparam int unsigned OpN   = 1 << OpW;
  localparam int unsigned SeqN  = 1 << SeqW;
  localparam int unsigned OpLsb = AddrW;
  localparam int unsigned ModeBit = AddrW + OpW;

  typedef struct packed {
    logic             mode;
    logic [OpW-1:0]   op;
    logic [AddrW-1:0] addr;
  } instr_t;
endpackage

// File: rtl/hw_onehot_dec.sv
module hw_onehot_dec #(
  parameter int unsigned SelW = 3,
  localparam int unsigned OutN = 1 << SelW
) (
  input  logic [SelW-1:0] sel_i,
  output logic [OutN-1:0] dec_o
);
  for (genvar g = 0; g < OutN; g++) begin : g_line
    assign dec_o[g] = (sel_i == SelW'(g));
  end
endmodule

// File: rtl/hw_instr_reg.sv
module hw_instr_reg
  import hw_ctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [InstrW-1:0] instr_i,
  output instr_t            ir_o,
  output logic              mode_o
);
  instr_t ir_q;
  logic   mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ir_q   <= '0;
      mode_q <= 1'b0;
    end else if (load_i) begin
      ir_q   <= instr_t'(instr_i);
      mode_q <= instr_i[ModeBit];
    end
  end

  assign ir_o   = ir_q;
  assign mode_o = mode_q;

  a_r1_load_captures: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (ir_q == instr_t'($past(instr_i))));
  a_r2_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(ir_q) && $stable(mode_q)));
  a_r4_mode_tracks_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q == ir_q.mode);
endmodule

// File: rtl/hw_seq_counter.sv
module hw_seq_counter
  import hw_ctl_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            inc_i,
  input  logic            clr_i,
  output logic [SeqW-1:0] cnt_o
);
  logic [SeqW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)      cnt_d = '0;
    else if (inc_i) cnt_d = cnt_q + 1'b1;  // natural wrap at 2**SeqW
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  a_r8_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
  a_r6_step_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && cnt_q != '1) |=> (cnt_q == SeqW'($past(cnt_q) + 1'b1)));
  a_r7_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && cnt_q == '1) |=> (cnt_q == '0));
  a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/hw_ctl_front.sv
module hw_ctl_front
  import hw_ctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ir_load_i,
  input  logic [InstrW-1:0] instr_i,
  input  logic              sc_inc_i,
  input  logic              sc_clr_i,
  output logic [OpN-1:0]    op_o,
  output logic              mode_o,
  output logic [AddrW-1:0]  addr_o,
  output logic [SeqN-1:0]   timing_o
);
  instr_t          ir;
  logic [SeqW-1:0] cnt;

  hw_instr_reg u_ir (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (ir_load_i),
    .instr_i (instr_i),
    .ir_o    (ir),
    .mode_o  (mode_o)
  );

  hw_onehot_dec #(.SelW(OpW)) u_op_dec (
    .sel_i (ir.op),
    .dec_o (op_o)
  );

  hw_seq_counter u_sc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (sc_inc_i),
    .clr_i  (sc_clr_i),
    .cnt_o  (cnt)
  );

  hw_onehot_dec #(.SelW(SeqW)) u_t_dec (
    .sel_i (cnt),
    .dec_o (timing_o)
  );

  assign addr_o = ir.addr;

  a_r3_op_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(op_o) && op_o[ir.op]);
  a_r5_timing_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(timing_o) && timing_o[cnt]);
  a_r8_t0_after_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_clr_i |=> timing_o[0]);
  a_r1_addr_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_load_i |=> (addr_o == $past(instr_i[AddrW-1:0])));
endmodule

// File: tb/hw_ctl_front_test.sv
module hw_ctl_front_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ir_load_i = 1'b0;
  logic [15:0] instr_i = '0;
  logic        sc_inc_i = 1'b0;
  logic        sc_clr_i = 1'b0;
  logic [7:0]  op_o;
  logic        mode_o;
  logic [11:0] addr_o;
  logic [15:0] timing_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] m_ir = '0;
  logic [3:0]  m_cnt = '0;

  always #5 clk_i = ~clk_i;

  hw_ctl_front uut (.*);

  function automatic logic [7:0] exp_op(logic [15:0] w);
    return 8'b1 << w[14:12];
  endfunction

  function automatic logic [15:0] exp_t(logic [3:0] c);
    return 16'b1 << c;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(bit ld, logic [15:0] w, bit inc, bit clr);
    string treq;
    @(negedge clk_i);
    ir_load_i = ld; instr_i = w; sc_inc_i = inc; sc_clr_i = clr;
    @(posedge clk_i);
    #2;
    if (ld) m_ir = w;
    if (clr)                     treq = "R8";
    else if (inc && m_cnt == 15) treq = "R7";
    else if (inc)                treq = "R6";
    else                         treq = "R9";
    if (clr) m_cnt = 0;
    else if (inc) m_cnt = m_cnt + 4'd1;
    chk(ld ? "R1 addr" : "R2 addr", 32'(addr_o), 32'(m_ir[11:0]));
    chk("R3 op", 32'(op_o), 32'(exp_op(m_ir)));
    chk("R4 mode", 32'(mode_o), 32'(m_ir[15]));
    chk({treq, " R5 timing"}, 32'(timing_o), 32'(exp_t(m_cnt)));
  endtask

  initial begin
    void'($urandom(32'd1311));
    #23;
    chk("R10 op", 32'(op_o), 32'h01);
    chk("R10 mode", 32'(mode_o), 32'h0);
    chk("R10 addr", 32'(addr_o), 32'h0);
    chk("R10 timing", 32'(timing_o), 32'h0001);
    rst_ni = 1'b1;
    // every opcode, both modes
    for (int k = 0; k < 16; k++) step(1'b1, {k[0], k[3:1], 12'(k * 273)}, 1'b0, 1'b0);
    // idle hold of IR and counter
    for (int k = 0; k < 5; k++) step(1'b0, 16'hFFFF, 1'b0, 1'b0);
    // full count through wrap
    for (int k = 0; k < 20; k++) step(1'b0, 16'h0000, 1'b1, 1'b0);
    // clear beats increment
    step(1'b0, 16'h1234, 1'b1, 1'b1);
    step(1'b1, 16'h8ABC, 1'b1, 1'b0);
    step(1'b0, 16'h0000, 1'b1, 1'b1);
    // random mix
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] & r[1], 16'($urandom), r[2] | r[3], (r[7:4] == 4'h0));
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule